// File: doc/BRIEF.md
# Two-Term Taylor Reciprocal Unit

This unit returns an approximation of 1/Y for an unsigned fixed-point operand. It is meant to sit behind a magnitude stage in a channel equalizer, where it turns the size of a per-subcarrier channel estimate into a gain. The operand has 2·HALF_W bits and two integer bits, so it covers values from zero up to just under four.

The operand is split into an upper half Yh and a lower half Yl. Both halves keep their original bit weights. A table indexed by Yh supplies 1/Yh². The difference Yh − Yl is formed in the same cycle. One multiplier then combines the two terms, which matches the first two terms of a Taylor expansion of 1/Y around Yh. The table is computed from the parameters during elaboration, so it contains no hand-written data. Each accepted operand gives one result a fixed two cycles later. A zero upper half cannot be inverted and is reported as a saturated result with a flag.

Top module: `recip_taylor`

## Requirements
- R1: For an operand code y whose upper half h = y[13:7] is nonzero, with lower half l = y[6:0], the result code is floor(((h·128 − l) · T(h)) / 2^10). The operand weights are 2^-12 per LSB, and the result is unsigned with 6 integer bits and 10 fraction bits (the default parameters, rounding off).
- R2: The table word for a nonzero upper half h is T(h) = floor(2^18 / h²). This is 1/Yh² with 8 fraction bits.
- R3: When the upper half is zero, the result is all ones (0xFFFF) and out_ovf is 1. For every other operand, out_ovf is 0.
- R4: out_vld is in_vld delayed by exactly two clock cycles. The result that accompanies out_vld belongs to the operand that was presented with in_vld two cycles earlier.
- R5: When in_vld is low, out_q and out_ovf do not change two cycles later. The operand presented in that cycle has no effect on them.
- R6: While rst_n is low, out_vld, out_q and out_ovf are all zero.
- R7: A new operand can be accepted in every cycle. Back-to-back operands produce back-to-back results, in the same order.
- R8: An operand that is a power of two with a zero lower half gives the exact reciprocal. For example, 1.0 (0x1000) gives 1.0 (0x0400), 2.0 gives 0.5, and 0.5 gives 2.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand qualifier |
| in_y | input | 14 | Operand, 2 integer and 12 fraction bits |
| out_vld | output | 1 | Result qualifier, in_vld delayed by two cycles |
| out_q | output | 16 | Reciprocal, 6 integer and 10 fraction bits |
| out_ovf | output | 1 | Set with a saturated result when the upper half is zero |

## Verification
The operands fall into four groups, and each group tests something different.
- Exact powers of two show whether the halves are weighted and aligned correctly, because any shift error moves the result by a whole factor of two.
- A pair of operands that share an upper half but differ in the lower half separates the difference term from the table term.
- The smallest nonzero upper half, alone and with a full lower half, exercises the largest table word and the largest product. The largest operand exercises the smallest table word.
- Zero and small operands below the first table step check the saturation path. Back-to-back operands and idle cycles carrying junk data check ordering and the hold behaviour.

// File: rtl/recip_pkg.sv
package recip_pkg;

   // Table word for index idx: floor(2^scale_log2 / idx^2); zero index yields zero.
   function automatic longint unsigned inv_sq_word(input int unsigned idx,
                                                   input int unsigned scale_log2);
      longint unsigned num;
      longint unsigned den;
      num = longint'(1) << scale_log2;
      den = longint'(idx) * longint'(idx);
      if (idx == 0) return 0;
      return num / den;
   endfunction

endpackage

// File: rtl/recip_lut.sv
module recip_lut #(
   parameter int IDX_W = 7,
   parameter int SCALE = 18,
   parameter int TW    = SCALE + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   output logic [TW-1:0]    word_q
);
   import recip_pkg::*;

   localparam int DEPTH = 1 << IDX_W;

   logic [TW-1:0] tbl [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam longint unsigned ENT = inv_sq_word(i, SCALE);
      assign tbl[i] = TW'(ENT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (en) word_q <= tbl[idx];
   end
endmodule

// File: rtl/recip_prep.sv
module recip_prep #(
   parameter int HALF_W = 7,
   parameter int OPW    = 2 * HALF_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_vld,
   input  logic [OPW-1:0] in_y,
   output logic           s_vld,
   output logic [OPW-1:0] s_diff,
   output logic           s_zero
);
   logic [HALF_W-1:0] hi;
   logic [HALF_W-1:0] lo;
   logic [OPW-1:0]    diff;

   assign hi   = in_y[OPW-1 -: HALF_W];
   assign lo   = in_y[HALF_W-1:0];
   assign diff = {hi, {HALF_W{1'b0}}} - {{HALF_W{1'b0}}, lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_vld  <= 1'b0;
         s_diff <= '0;
         s_zero <= 1'b0;
      end else begin
         s_vld <= in_vld;
         if (in_vld) begin
            s_diff <= diff;
            s_zero <= (hi == '0);
         end
      end
   end
endmodule

// File: rtl/recip_mul.sv
module recip_mul #(
   parameter int OPW       = 14,
   parameter int TW        = 19,
   parameter int OW        = 16,
   parameter int SHIFT     = 10,
   parameter bit ROUND_OUT = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           s_vld,
   input  logic [OPW-1:0] s_diff,
   input  logic [TW-1:0]  s_word,
   input  logic           s_zero,
   output logic           out_vld,
   output logic [OW-1:0]  out_q,
   output logic           out_ovf
);
   localparam int PW = OPW + TW;

   logic [PW-1:0] prod;
   logic [PW:0]   adj;
   logic [PW:0]   shifted;
   logic          big;
   logic          sat;
   logic [OW-1:0] q;

   assign prod = PW'(s_diff) * PW'(s_word);

   if (ROUND_OUT && SHIFT > 0) begin : g_rnd
      assign adj = {1'b0, prod} + ((PW+1)'(1) << (SHIFT - 1));
   end else begin : g_trunc
      assign adj = {1'b0, prod};
   end

   assign shifted = adj >> SHIFT;

   if (PW + 1 > OW) begin : g_chk
      assign big = |shifted[PW:OW];
   end else begin : g_nochk
      assign big = 1'b0;
   end

   assign sat = s_zero | big;
   assign q   = sat ? {OW{1'b1}} : shifted[OW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_q   <= '0;
         out_ovf <= 1'b0;
      end else begin
         out_vld <= s_vld;
         if (s_vld) begin
            out_q   <= q;
            out_ovf <= sat;
         end
      end
   end
endmodule

// File: rtl/recip_taylor.sv
module recip_taylor #(
   parameter int HALF_W    = 7,
   parameter int TBL_FRAC  = 8,
   parameter int OUT_INT   = 6,
   parameter int OUT_FRAC  = 10,
   parameter bit ROUND_OUT = 1'b0,
   localparam int OPW      = 2 * HALF_W,
   localparam int OW       = OUT_INT + OUT_FRAC
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_vld,
   input  logic [OPW-1:0] in_y,
   output logic           out_vld,
   output logic [OW-1:0]  out_q,
   output logic           out_ovf
);
   localparam int SCALE = 2 * (HALF_W - 2) + TBL_FRAC;
   localparam int TW    = SCALE + 1;
   localparam int SHIFT = (OPW - 2) + TBL_FRAC - OUT_FRAC;

   if (HALF_W < 3 || HALF_W > 12) begin : g_bad_half
      $error("HALF_W out of supported range");
   end
   if (OUT_INT < HALF_W - 1) begin : g_bad_int
      $error("OUT_INT too small for largest reciprocal");
   end
   if (SHIFT < 0) begin : g_bad_shift
      $error("OUT_FRAC exceeds available product fraction");
   end

   logic           s_vld;
   logic [OPW-1:0] s_diff;
   logic           s_zero;
   logic [TW-1:0]  s_word;

   recip_prep #(.HALF_W(HALF_W), .OPW(OPW)) u_prep (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_vld (in_vld),
      .in_y   (in_y),
      .s_vld  (s_vld),
      .s_diff (s_diff),
      .s_zero (s_zero)
   );

   recip_lut #(.IDX_W(HALF_W), .SCALE(SCALE), .TW(TW)) u_lut (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (in_vld),
      .idx    (in_y[OPW-1 -: HALF_W]),
      .word_q (s_word)
   );

   recip_mul #(.OPW(OPW), .TW(TW), .OW(OW), .SHIFT(SHIFT),
               .ROUND_OUT(ROUND_OUT)) u_mul (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_vld   (s_vld),
      .s_diff  (s_diff),
      .s_word  (s_word),
      .s_zero  (s_zero),
      .out_vld (out_vld),
      .out_q   (out_q),
      .out_ovf (out_ovf)
   );
endmodule

// File: rtl/recip_taylor_chk.sv
module recip_taylor_chk #(
   parameter int HALF_W = 7,
   parameter int OPW    = 2 * HALF_W,
   parameter int OW     = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_vld,
   input logic [OPW-1:0] in_y,
   input logic           out_vld,
   input logic [OW-1:0]  out_q,
   input logic           out_ovf
);
   logic hi_zero;
   assign hi_zero = (in_y[OPW-1 -: HALF_W] == '0);

   a_r4_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> ##2 out_vld);

   a_r4_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |-> ##2 !out_vld);

   a_r3_sat_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && hi_zero) |-> ##2 (out_ovf && out_q == {OW{1'b1}}));

   a_r3_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !hi_zero) |-> ##2 !out_ovf);

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |-> ##2 ($stable(out_q) && $stable(out_ovf)));

   always_comb begin
      if (!rst_n) begin
         a_r6_reset_clear: assert (!out_vld || $isunknown(out_vld));
      end
   end
endmodule

bind recip_taylor recip_taylor_chk #(.HALF_W(HALF_W), .OPW(OPW), .OW(OW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .in_y    (in_y),
   .out_vld (out_vld),
   .out_q   (out_q),
   .out_ovf (out_ovf)
);

// File: tb/tb_recip_taylor.sv
module tb_recip_taylor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [13:0] in_y = '0;
   logic        out_vld;
   logic [15:0] out_q;
   logic        out_ovf;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   recip_taylor dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_y(in_y),
      .out_vld(out_vld), .out_q(out_q), .out_ovf(out_ovf)
   );

   // Expected result from R1/R2/R3.
   function automatic logic [16:0] model(input logic [13:0] y);
      longint unsigned h, l, d, t, p;
      h = longint'(y[13:7]);
      l = longint'(y[6:0]);
      if (h == 0) return {1'b1, 16'hFFFF};
      d = h * 128 - l;
      t = (longint'(1) << 18) / (h * h);
      p = (d * t) >> 10;
      if (p > 65535) return {1'b1, 16'hFFFF};
      return {1'b0, p[15:0]};
   endfunction

   task automatic check(input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%h expected=0x%h", req, act, exp);
      end
   endtask

   task automatic check_res(input string req, input logic [13:0] y);
      logic [16:0] e;
      e = model(y);
      check({req, " vld"}, {15'd0, out_vld}, 16'd1);
      check({req, " q"}, out_q, e[15:0]);
      check({req, " ovf"}, {15'd0, out_ovf}, {15'd0, e[16]});
   endtask

   task automatic send_one(input string req, input logic [13:0] y);
      @(negedge clk); in_vld = 1'b1; in_y = y;
      @(negedge clk); in_vld = 1'b0; in_y = 14'h2AAA;
      @(negedge clk);
      check_res(req, y);
   endtask

   task automatic t_reset;
      check("R6 vld", {15'd0, out_vld}, 16'd0);
      check("R6 q", out_q, 16'd0);
      check("R6 ovf", {15'd0, out_ovf}, 16'd0);
   endtask

   task automatic t_powers;
      send_one("R8 one", 14'h1000);
      check("R8 one exact", out_q, 16'h0400);
      send_one("R8 two", 14'h2000);
      check("R8 two exact", out_q, 16'h0200);
      send_one("R8 half", 14'h0800);
      check("R8 half exact", out_q, 16'h0800);
   endtask

   task automatic t_main;
      send_one("R1 low half zero", 14'h1080);
      send_one("R1 low half set", 14'h10B2);
      send_one("R1 max operand", 14'h3FFF);
      send_one("R2 smallest hi", 14'h0080);
      send_one("R2 smallest hi full lo", 14'h00FF);
      send_one("R1 mid", 14'h2A5C);
   endtask

   task automatic t_sat;
      send_one("R3 zero", 14'h0000);
      send_one("R3 small", 14'h0064);
      send_one("R3 flag clears", 14'h1000);
      check("R3 ovf low", {15'd0, out_ovf}, 16'd0);
   endtask

   task automatic t_hold;
      logic [15:0] q0;
      logic        o0;
      send_one("R5 setup", 14'h1234);
      q0 = out_q; o0 = out_ovf;
      @(negedge clk); in_vld = 1'b0; in_y = 14'h0000;
      @(negedge clk); in_y = 14'h3FFF;
      @(negedge clk); in_y = 14'h0001;
      check("R5 q hold", out_q, q0);
      check("R5 ovf hold", {15'd0, out_ovf}, {15'd0, o0});
      check("R4 idle vld", {15'd0, out_vld}, 16'd0);
   endtask

   task automatic t_burst;
      logic [13:0] v [4];
      v[0] = 14'h1000; v[1] = 14'h0000; v[2] = 14'h3001; v[3] = 14'h0199;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         if (c >= 2) check_res("R7 burst", v[c-2]);
         if (c < 4) begin in_vld = 1'b1; in_y = v[c]; end
         else begin in_vld = 1'b0; in_y = '0; end
      end
      @(negedge clk);
      check("R4 vld drops", {15'd0, out_vld}, 16'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_powers();
      t_main();
      t_sat();
      t_hold();
      t_burst();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule